// File: doc/BRIEF.md
# Two-Stage Pipeline Dispatch Control

This block steers instructions from the front stage of a two-stage in-order pipeline into the back stage. The front stage fetches, decodes and reads registers. The back stage executes, accesses memory and writes back. Each cycle the block gets a decoded instruction from outside: valid flags and indices for two sources and one destination, opaque decoded fields, two register read values and a predicted next PC. It checks the sources against a table of destinations still in flight. When no read-after-write conflict exists and the single-entry stage buffer can take the instruction, the block dispatches it. The PC then advances to the predicted value.

The buffered entry is shown to the back stage together with its PC, its predicted next PC and a live flag. The live flag is set when the epoch stored with the entry matches the current epoch. When the back stage reports completion, the block works out the resolved next PC and compares it with the prediction. On a mismatch it steers the PC to the resolved address and flips the epoch, so any wrong-path entry already dispatched is later dropped.

The tracker is searched before the completing entry's removal is applied. An instruction that depends on the entry leaving in the same cycle therefore waits one more cycle. Because of this, an external register file with write-before-read forwarding is not needed.

Top module: `twoStageDispatch`

## Requirements
- R1: After reset, `fetchPc` equals the `RESET_PC` parameter, `exValid` is 0 and `epoch` is 0.
- R2: `dispatched` is 0 and `fetchPc` holds when a source whose valid flag is 1 matches the valid destination of an entry that was in the buffer at the start of the cycle. This holds even if that entry completes in the same cycle. A source whose valid flag is 0 never causes a stall, whatever its index.
- R3: `dispatched` is 1 exactly when `instValid` is 1, no R2 conflict exists, and the buffer is empty or `exDone` is 1. When it is 1 and no redirect occurs, `fetchPc` takes the value of `predNextPc` on the next clock edge. While `dispatched` is 0 and no redirect occurs, `fetchPc` holds.
- R4: In the cycle after a dispatch, the buffer outputs show the dispatching PC, `predNextPc`, `decFields`, `rdVal1`, `rdVal2` and the destination valid flag and index. The entry is stored with the epoch that was current when it was dispatched.
- R5: A dispatched destination counts as in flight until its entry completes. If one dispatch inserts a register and one completion removes the same register in the same cycle, that register stays in flight.
- R6: The resolved next PC is `brTarget` when `brTaken` is 1 and `exPc + 4` otherwise. `redirect` is 1 when a live entry completes and the resolved next PC differs from `exPredPc`. On the next edge `fetchPc` becomes the resolved value and `epoch` flips.
- R7: In a cycle with a redirect, the PC update from redirect wins over a dispatch in the same cycle. An instruction dispatched in that cycle still enters the buffer, carries the old epoch and shows `exLive` = 0.
- R8: An entry that is not live never raises `redirect` or `wbEn`. It still leaves the buffer on `exDone`, and its destination is released from tracking.
- R9: `wbEn` is 1 exactly when a live entry with a valid destination completes.
- R10: While the buffer is full and `exDone` is 0, nothing is dispatched, and both `fetchPc` and the buffer contents hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchPc | output | AW | PC of the instruction currently in the front stage |
| predNextPc | input | AW | Predicted next PC for the front instruction |
| instValid | input | 1 | Front stage holds a decoded instruction |
| src1Valid | input | 1 | First source register is used |
| src1Idx | input | RW | First source register index |
| src2Valid | input | 1 | Second source register is used |
| src2Idx | input | RW | Second source register index |
| dstValid | input | 1 | Instruction writes a destination register |
| dstIdx | input | RW | Destination register index |
| decFields | input | FW | Opaque decoded instruction fields |
| rdVal1 | input | DW | Register read value for the first source |
| rdVal2 | input | DW | Register read value for the second source |
| dispatched | output | 1 | Front instruction is enqueued this cycle |
| exValid | output | 1 | Stage buffer holds an entry |
| exLive | output | 1 | Buffered entry's epoch matches the current epoch |
| exPc | output | AW | PC of the buffered entry |
| exPredPc | output | AW | Predicted next PC of the buffered entry |
| exFields | output | FW | Decoded fields of the buffered entry |
| exVal1 | output | DW | First register value of the buffered entry |
| exVal2 | output | DW | Second register value of the buffered entry |
| exDstValid | output | 1 | Buffered entry has a destination |
| exDstIdx | output | RW | Destination index of the buffered entry |
| exDone | input | 1 | Back stage completes the buffered entry this cycle |
| brTaken | input | 1 | Buffered branch is taken |
| brTarget | input | AW | Branch target of the buffered entry |
| redirect | output | 1 | Misprediction: PC is steered and the epoch flips |
| wbEn | output | 1 | Write-back permitted for the completing entry |
| epoch | output | 1 | Current epoch bit |

## Verification
Internal state in this block is visible at the ports almost at once. A tracker counter left set after its entry completes shows up as a stuck `dispatched` = 0 for a later reader of that register in the very next cycle. A counter cleared too early lets a dependent instruction dispatch one cycle early. A wrong epoch bit shows as a wrong `exLive` on the next buffered entry. That in turn produces a spurious or missing `redirect` or `wbEn` when the entry completes. PC mistakes show in `fetchPc` one edge after the decision and in `exPc` one edge after the next dispatch.

// File: rtl/pipeDefs_pkg.sv
package pipeDefs_pkg;
  // Strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic enq;       // load the stage buffer, advance PC unless steered
    logic redirect;  // steer PC to the resolved next PC
  } ctlStrobes_t;
endpackage

// File: rtl/hazardTracker.sv
module hazardTracker #(
  parameter int RW   = 5,
  parameter int MAXF = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          insValid,
  input  logic [RW-1:0] insIdx,
  input  logic          remValid,
  input  logic [RW-1:0] remIdx,
  input  logic          s1Valid,
  input  logic [RW-1:0] s1Idx,
  input  logic          s2Valid,
  input  logic [RW-1:0] s2Idx,
  output logic          hit1,
  output logic          hit2
);
  localparam int NREG = 1 << RW;
  localparam int CW   = $clog2(MAXF + 1);

  logic [NREG-1:0] busy;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [CW-1:0] cnt;
    logic insHit, remHit;
    assign insHit  = insValid && (insIdx == RW'(r));
    assign remHit  = remValid && (remIdx == RW'(r));
    assign busy[r] = (cnt != '0);

    always_ff @(posedge clk) begin
      if (!rstN)                 cnt <= '0;
      else if (insHit && !remHit) cnt <= cnt + CW'(1);
      else if (remHit && !insHit) cnt <= cnt - CW'(1);
    end

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
      remHit |-> (cnt != '0));
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
      (insHit && !remHit) |-> (cnt < CW'(MAXF)));
  end

  // search sees the count before this cycle's removal takes effect
  assign hit1 = s1Valid && busy[s1Idx];
  assign hit2 = s2Valid && busy[s2Idx];
endmodule

// File: rtl/dispatchCtl.sv
module dispatchCtl
  import pipeDefs_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instValid,
  input  logic          src1Valid,
  input  logic [RW-1:0] src1Idx,
  input  logic          src2Valid,
  input  logic [RW-1:0] src2Idx,
  input  logic          dstValid,
  input  logic [RW-1:0] dstIdx,
  input  logic          exDone,
  input  logic          mispredict,
  input  logic          bufDstValid,
  input  logic [RW-1:0] bufDstIdx,
  input  logic          bufEpoch,
  output ctlStrobes_t   strobes,
  output logic          bufValid,
  output logic          live,
  output logic          wbEn,
  output logic          epoch,
  output logic          dispatched
);
  localparam int MAX_INFLIGHT = 1;  // single-entry stage buffer

  logic bufValidQ, epochQ;
  logic hit1, hit2, hazard;
  logic enq, deq, steer;

  hazardTracker #(.RW(RW), .MAXF(MAX_INFLIGHT)) u_track (
    .clk(clk), .rstN(rstN),
    .insValid(enq && dstValid), .insIdx(dstIdx),
    .remValid(deq && bufDstValid), .remIdx(bufDstIdx),
    .s1Valid(src1Valid), .s1Idx(src1Idx),
    .s2Valid(src2Valid), .s2Idx(src2Idx),
    .hit1(hit1), .hit2(hit2)
  );

  always_comb begin
    hazard = hit1 || hit2;
    live   = bufValidQ && (bufEpoch == epochQ);
    deq    = bufValidQ && exDone;
    enq    = instValid && !hazard && (!bufValidQ || exDone);
    steer  = deq && live && mispredict;
    wbEn   = deq && live && bufDstValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValidQ <= 1'b0;
      epochQ    <= 1'b0;
    end else begin
      if (enq)      bufValidQ <= 1'b1;
      else if (deq) bufValidQ <= 1'b0;
      if (steer)    epochQ    <= ~epochQ;
    end
  end

  assign strobes.enq      = enq;
  assign strobes.redirect = steer;
  assign bufValid   = bufValidQ;
  assign epoch      = epochQ;
  assign dispatched = enq;

  // R6
  epoch_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    steer |=> (epochQ != $past(epochQ)));
  // R8
  stale_epoch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufValidQ && !live) |=> $stable(epochQ));
  // R10
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufValidQ && !exDone) |=> bufValidQ);
endmodule

// File: rtl/dispatchPath.sv
module dispatchPath
  import pipeDefs_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter int            FW       = 16,
  parameter int            RW       = 5,
  parameter logic [AW-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   strobes,
  input  logic [AW-1:0] predNextPc,
  input  logic [FW-1:0] decFields,
  input  logic [DW-1:0] rdVal1,
  input  logic [DW-1:0] rdVal2,
  input  logic          dstValid,
  input  logic [RW-1:0] dstIdx,
  input  logic          epoch,
  input  logic          brTaken,
  input  logic [AW-1:0] brTarget,
  output logic [AW-1:0] pc,
  output logic          mispredict,
  output logic [AW-1:0] exPc,
  output logic [AW-1:0] exPredPc,
  output logic [FW-1:0] exFields,
  output logic [DW-1:0] exVal1,
  output logic [DW-1:0] exVal2,
  output logic          exDstValid,
  output logic [RW-1:0] exDstIdx,
  output logic          exEpoch
);
  localparam logic [AW-1:0] INST_BYTES = AW'(4);

  logic [AW-1:0] pcQ, resolved;

  always_comb begin
    resolved   = brTaken ? brTarget : (exPc + INST_BYTES);
    mispredict = (resolved != exPredPc);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 pcQ <= RESET_PC;
    else if (strobes.redirect) pcQ <= resolved;
    else if (strobes.enq)      pcQ <= predNextPc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      exPc       <= '0;
      exPredPc   <= '0;
      exFields   <= '0;
      exVal1     <= '0;
      exVal2     <= '0;
      exDstValid <= 1'b0;
      exDstIdx   <= '0;
      exEpoch    <= 1'b0;
    end else if (strobes.enq) begin
      exPc       <= pcQ;
      exPredPc   <= predNextPc;
      exFields   <= decFields;
      exVal1     <= rdVal1;
      exVal2     <= rdVal2;
      exDstValid <= dstValid;
      exDstIdx   <= dstIdx;
      exEpoch    <= epoch;
    end
  end

  assign pc = pcQ;

  // R3
  pc_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.enq && !strobes.redirect) |=> (pcQ == $past(predNextPc)));
  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.enq && !strobes.redirect) |=> $stable(pcQ));
  // R7
  pc_steer_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.redirect |=> (pcQ == $past(resolved)));
  // R4
  payload_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.enq |=> ($stable(exPc) && $stable(exEpoch)));
endmodule

// File: rtl/twoStageDispatch.sv
module twoStageDispatch
  import pipeDefs_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter int            FW       = 16,
  parameter int            RW       = 5,
  parameter logic [AW-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic          clk,
  input  logic          rstN,
  output logic [AW-1:0] fetchPc,
  input  logic [AW-1:0] predNextPc,
  input  logic          instValid,
  input  logic          src1Valid,
  input  logic [RW-1:0] src1Idx,
  input  logic          src2Valid,
  input  logic [RW-1:0] src2Idx,
  input  logic          dstValid,
  input  logic [RW-1:0] dstIdx,
  input  logic [FW-1:0] decFields,
  input  logic [DW-1:0] rdVal1,
  input  logic [DW-1:0] rdVal2,
  output logic          dispatched,
  output logic          exValid,
  output logic          exLive,
  output logic [AW-1:0] exPc,
  output logic [AW-1:0] exPredPc,
  output logic [FW-1:0] exFields,
  output logic [DW-1:0] exVal1,
  output logic [DW-1:0] exVal2,
  output logic          exDstValid,
  output logic [RW-1:0] exDstIdx,
  input  logic          exDone,
  input  logic          brTaken,
  input  logic [AW-1:0] brTarget,
  output logic          redirect,
  output logic          wbEn,
  output logic          epoch
);
  ctlStrobes_t strobes;
  logic        mispredict, exEpoch;

  dispatchCtl #(.RW(RW)) u_ctl (
    .clk(clk), .rstN(rstN),
    .instValid(instValid),
    .src1Valid(src1Valid), .src1Idx(src1Idx),
    .src2Valid(src2Valid), .src2Idx(src2Idx),
    .dstValid(dstValid), .dstIdx(dstIdx),
    .exDone(exDone), .mispredict(mispredict),
    .bufDstValid(exDstValid), .bufDstIdx(exDstIdx), .bufEpoch(exEpoch),
    .strobes(strobes), .bufValid(exValid), .live(exLive),
    .wbEn(wbEn), .epoch(epoch), .dispatched(dispatched)
  );

  dispatchPath #(.AW(AW), .DW(DW), .FW(FW), .RW(RW), .RESET_PC(RESET_PC)) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .predNextPc(predNextPc), .decFields(decFields),
    .rdVal1(rdVal1), .rdVal2(rdVal2),
    .dstValid(dstValid), .dstIdx(dstIdx), .epoch(epoch),
    .brTaken(brTaken), .brTarget(brTarget),
    .pc(fetchPc), .mispredict(mispredict),
    .exPc(exPc), .exPredPc(exPredPc), .exFields(exFields),
    .exVal1(exVal1), .exVal2(exVal2),
    .exDstValid(exDstValid), .exDstIdx(exDstIdx), .exEpoch(exEpoch)
  );

  assign redirect = strobes.redirect;
endmodule

// File: tb/twoStageDispatch_test.sv
module twoStageDispatch_test;
  localparam int AW = 32, DW = 32, FW = 16, RW = 5;
  localparam logic [AW-1:0] RPC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rstN;
  logic [AW-1:0] fetchPc, predNextPc, exPc, exPredPc, brTarget;
  logic instValid, src1Valid, src2Valid, dstValid;
  logic [RW-1:0] src1Idx, src2Idx, dstIdx, exDstIdx;
  logic [FW-1:0] decFields, exFields;
  logic [DW-1:0] rdVal1, rdVal2, exVal1, exVal2;
  logic dispatched, exValid, exLive, exDstValid, exDone, brTaken, redirect, wbEn, epoch;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  twoStageDispatch #(.AW(AW), .DW(DW), .FW(FW), .RW(RW), .RESET_PC(RPC)) uut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predNextPc(predNextPc),
    .instValid(instValid), .src1Valid(src1Valid), .src1Idx(src1Idx),
    .src2Valid(src2Valid), .src2Idx(src2Idx), .dstValid(dstValid), .dstIdx(dstIdx),
    .decFields(decFields), .rdVal1(rdVal1), .rdVal2(rdVal2),
    .dispatched(dispatched), .exValid(exValid), .exLive(exLive), .exPc(exPc),
    .exPredPc(exPredPc), .exFields(exFields), .exVal1(exVal1), .exVal2(exVal2),
    .exDstValid(exDstValid), .exDstIdx(exDstIdx), .exDone(exDone),
    .brTaken(brTaken), .brTarget(brTarget), .redirect(redirect), .wbEn(wbEn),
    .epoch(epoch)
  );

  task automatic chkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic front(input logic v, input logic s1v, input logic [RW-1:0] s1,
                       input logic s2v, input logic [RW-1:0] s2,
                       input logic dv, input logic [RW-1:0] d, input logic [AW-1:0] pred);
    instValid = v; src1Valid = s1v; src1Idx = s1; src2Valid = s2v; src2Idx = s2;
    dstValid = dv; dstIdx = d; predNextPc = pred;
  endtask

  task automatic back(input logic done, input logic tk, input logic [AW-1:0] tgt);
    exDone = done; brTaken = tk; brTarget = tgt;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic tReset();
    chkEq("R1 fetchPc", fetchPc, RPC);
    chkEq("R1 exValid", exValid, 0);
    chkEq("R1 epoch", epoch, 0);
  endtask

  task automatic tDispatch();
    front(1, 1, 1, 1, 2, 1, 3, 32'h1004);
    decFields = 16'hA5C3; rdVal1 = 32'h1111_2222; rdVal2 = 32'h3333_4444;
    back(0, 0, 0);
    #1 chkEq("R3 dispatch into empty buffer", dispatched, 1);
    tick();
    chkEq("R3 pc advances", fetchPc, 32'h1004);
    chkEq("R4 exValid", exValid, 1);
    chkEq("R4 exPc", exPc, 32'h1000);
    chkEq("R4 exPredPc", exPredPc, 32'h1004);
    chkEq("R4 exFields", exFields, 16'hA5C3);
    chkEq("R4 exVal1", exVal1, 32'h1111_2222);
    chkEq("R4 exVal2", exVal2, 32'h3333_4444);
    chkEq("R4 exDst", {exDstValid, exDstIdx}, {1'b1, 5'd3});
    chkEq("R4 exLive", exLive, 1);
  endtask

  task automatic tBackpressure();
    front(1, 1, 5, 1, 6, 1, 7, 32'h1008);
    decFields = 16'h0BAD; rdVal1 = 32'hDEAD_0001; rdVal2 = 32'hDEAD_0002;
    back(0, 0, 0);
    #1 chkEq("R10 no dispatch when full", dispatched, 0);
    tick();
    chkEq("R10 pc holds", fetchPc, 32'h1004);
    chkEq("R10 exPc holds", exPc, 32'h1000);
    chkEq("R10 exVal1 holds", exVal1, 32'h1111_2222);
  endtask

  task automatic tRawStall();
    front(1, 1, 3, 0, 0, 1, 7, 32'h1008);
    back(1, 0, 0);  // resolves to 0x1004, matches prediction
    #1 chkEq("R2 stall on src1 match", dispatched, 0);
    chkEq("R9 wbEn live with dst", wbEn, 1);
    chkEq("R6 no redirect on match", redirect, 0);
    tick();
    chkEq("R8 entry dequeued", exValid, 0);
    chkEq("R2 pc holds during stall", fetchPc, 32'h1004);
    back(0, 0, 0);
    #1 chkEq("R5 released after completion", dispatched, 1);
    tick();
    chkEq("R4 exPc second", exPc, 32'h1004);
    chkEq("R3 pc advances", fetchPc, 32'h1008);
  endtask

  task automatic tRedirect();
    front(1, 0, 7, 1, 7, 0, 0, 32'h100C);
    back(1, 1, 32'h2000);
    #1 chkEq("R2 stall on src2 match", dispatched, 0);
    chkEq("R6 redirect on taken", redirect, 1);
    tick();
    chkEq("R6 pc steered", fetchPc, 32'h2000);
    chkEq("R6 epoch flips", epoch, 1);
    chkEq("R6 buffer empty", exValid, 0);
  endtask

  task automatic tInvalidSrc();
    front(1, 1, 8, 1, 8, 1, 9, 32'h2004);
    back(0, 0, 0);
    tick();
    front(1, 0, 9, 1, 4, 0, 0, 32'h2008);
    back(1, 0, 0);  // 0x2000+4 equals prediction
    #1 chkEq("R2 invalid source ignored", dispatched, 1);
    chkEq("R6 not-taken matches", redirect, 0);
    tick();
    chkEq("R3 dispatch while dequeuing", exPc, 32'h2004);
    chkEq("R4 no dst carried", exDstValid, 0);
    chkEq("R4 epoch carried live", exLive, 1);
    chkEq("R3 pc", fetchPc, 32'h2008);
  endtask

  task automatic tPriority();
    front(1, 1, 1, 1, 2, 1, 11, 32'h200C);
    back(1, 1, 32'h3000);
    #1 chkEq("R7 redirect", redirect, 1);
    chkEq("R7 dispatch same cycle", dispatched, 1);
    chkEq("R9 no wbEn without dst", wbEn, 0);
    tick();
    chkEq("R7 redirect wins pc", fetchPc, 32'h3000);
    chkEq("R7 epoch back to 0", epoch, 0);
    chkEq("R7 wrong-path entry", exPc, 32'h2008);
    chkEq("R7 entry not live", exLive, 0);
  endtask

  task automatic tStale();
    front(1, 1, 11, 0, 0, 1, 12, 32'h3004);
    back(1, 1, 32'h5000);
    #1 chkEq("R8 stale no redirect", redirect, 0);
    chkEq("R8 stale no wbEn", wbEn, 0);
    chkEq("R2 stale dst still tracked", dispatched, 0);
    tick();
    chkEq("R8 stale dequeued", exValid, 0);
    chkEq("R8 epoch unchanged", epoch, 0);
    chkEq("R8 pc unchanged", fetchPc, 32'h3000);
    back(0, 0, 0);
    #1 chkEq("R8 stale dst released", dispatched, 1);
    tick();
    chkEq("R4 live again", exLive, 1);
    chkEq("R3 pc", fetchPc, 32'h3004);
  endtask

  task automatic tIdle();
    front(0, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFF0);
    back(1, 1, 32'h3004);  // taken to the predicted address: no redirect
    #1 chkEq("R3 no dispatch without instValid", dispatched, 0);
    chkEq("R6 taken equal to prediction", redirect, 0);
    chkEq("R9 wbEn live with dst", wbEn, 1);
    tick();
    chkEq("R3 pc holds idle", fetchPc, 32'h3004);
    chkEq("R3 buffer drained", exValid, 0);
  endtask

  task automatic tWaw();
    front(1, 0, 0, 0, 0, 1, 13, 32'h3008);
    back(0, 0, 0);
    tick();
    front(1, 0, 0, 0, 0, 1, 13, 32'h300C);
    back(1, 0, 0);
    #1 chkEq("R5 same dst insert and remove", dispatched, 1);
    tick();
    front(1, 1, 13, 0, 0, 0, 0, 32'h3010);
    back(1, 0, 0);
    #1 chkEq("R5 dst still in flight", dispatched, 0);
    tick();
    back(0, 0, 0);
    #1 chkEq("R5 released", dispatched, 1);
    tick();
    chkEq("R3 pc", fetchPc, 32'h3010);
  endtask

  initial begin
    rstN = 1'b0;
    front(0, 0, 0, 0, 0, 0, 0, 0);
    decFields = '0; rdVal1 = '0; rdVal2 = '0;
    back(0, 0, 0);
    repeat (3) @(posedge clk);
    #1 tReset();
    rstN = 1'b1;
    tDispatch();
    tBackpressure();
    tRawStall();
    tRedirect();
    tInvalidSrc();
    tPriority();
    tStale();
    tIdle();
    tWaw();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule